// File: doc/BRIEF.md
# Key-Gated Breakpoint Configuration Register Bank

This block holds the four configuration words that steer an extended breakpoint matcher: a control byte, a 32-bit data comparand, a 32-bit data don't-care mask and a 12-bit address don't-care mask. The processor core reaches it through a register-access port. A request carries a 32-bit register index, a read/write flag, write data and a separate 32-bit key operand. The bank answers one cycle later with a single done pulse, the read data and a fault bit.

No access completes unless the key operand equals the fixed password 0x9C5A203A. A request with any other key, or with an index that is not one of the four assigned indices, completes as a general-protection fault. Such a request changes no register and returns zero data. The stored values drive the breakpoint matcher at all times. The top bit of the control byte is a separate mode-entry flag. It is routed on its own output and is kept apart from the matching controls. Privilege checks and exception delivery belong to the requester, so this block only reports the fault.

Top module: `dbgcfg_bank`

## Requirements
- R1: While reset is active, and after it is released, all four registers read as zero, every configuration output is zero and `rsp_done` is low.
- R2: A write with the correct key (0x9C5A203A) to an assigned index updates only that register, and the new value appears on its configuration output in the cycle that carries the done pulse. Without a granted write, no register changes.
- R3: A read with the correct key to an assigned index returns the register value, zero-extended to 32 bits, on `rsp_rdata` together with the done pulse, with `rsp_fault` low. A write response returns zero data.
- R4: A request whose key differs from 0x9C5A203A in any bit responds with `rsp_fault` high and `rsp_rdata` zero, and leaves every register unchanged.
- R5: The assigned indices are 0xC0011024 (control), 0xC0011025 (data comparand), 0xC0011026 (data mask) and 0xC0011027 (address mask). Any other index faults, even with the correct key, and leaves every register unchanged.
- R6: Stored widths are 8 bits for control, 32 bits for each data register and 12 bits for the address mask. Write-data bits above a register's width are dropped, and they read back as zero.
- R7: Control bit 7 drives only `cfg_mode_enter`. Control bits 6..0 drive `cfg_ctrl`.
- R8: Each cycle with `req_valid` high produces exactly one cycle of `rsp_done` on the next clock. With no request, `rsp_done`, `rsp_fault` and `rsp_rdata` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | One-cycle access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_index | input | 32 | Register index |
| req_wdata | input | 32 | Write data |
| req_key | input | 32 | Key operand compared with the password |
| rsp_done | output | 1 | Response pulse, one cycle after the request |
| rsp_rdata | output | 32 | Read data, zero on writes and faults |
| rsp_fault | output | 1 | General-protection fault flag |
| cfg_ctrl | output | 7 | Control bits 6..0 to the matcher |
| cfg_mode_enter | output | 1 | Control bit 7, separate mode-entry flag |
| cfg_dmatch | output | 32 | Data comparand |
| cfg_dmask | output | 32 | Data don't-care mask |
| cfg_amask | output | 12 | Address don't-care mask |

## Verification
A granted write commits its register and emits its response on the same clock edge. The configuration output therefore changes in exactly the cycle that the done pulse marks. The bench drives a write and, on the very next cycle, a read of the same index. It expects the write's done pulse and the new configuration value together, and then expects the read to return that new value with no stall. A wrong-key write placed between two good reads must fault and must leave the value that the second read returns unchanged.

// File: rtl/dbgcfg_pkg.sv
package dbgcfg_pkg;

  localparam int unsigned DATA_W     = 32;
  localparam int unsigned NUM_REGS   = 4;
  localparam int unsigned SLOT_W     = $clog2(NUM_REGS);
  localparam logic [DATA_W-1:0] ACCESS_KEY = 32'h9C5A_203A;
  localparam logic [DATA_W-1:0] BASE_INDEX = 32'hC001_1024;

  typedef enum logic [SLOT_W-1:0] {
    SLOT_CTRL   = 2'd0,
    SLOT_DMATCH = 2'd1,
    SLOT_DMASK  = 2'd2,
    SLOT_AMASK  = 2'd3
  } slot_e;

  // Stored width of each slot.
  function automatic int unsigned slot_width(int unsigned s);
    case (s)
      0:       return 8;
      1:       return 32;
      2:       return 32;
      default: return 12;
    endcase
  endfunction

endpackage

// File: rtl/dbgcfg_rst_sync.sv
module dbgcfg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;

endmodule

// File: rtl/dbgcfg_decode.sv
module dbgcfg_decode
  import dbgcfg_pkg::*;
(
  input  logic                req_valid,
  input  logic [DATA_W-1:0]   req_index,
  input  logic [DATA_W-1:0]   req_key,
  output logic                grant,
  output logic                fault,
  output logic [SLOT_W-1:0]   slot,
  output logic [NUM_REGS-1:0] hit
);

  logic [DATA_W-1:0] offset;
  logic              key_ok;
  logic              in_range;

  always_comb begin
    offset   = req_index - BASE_INDEX;
    in_range = (offset < DATA_W'(NUM_REGS));
    key_ok   = (req_key == ACCESS_KEY);
    slot     = offset[SLOT_W-1:0];
    grant    = req_valid && key_ok && in_range;
    fault    = req_valid && !grant;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_hit
    assign hit[g] = grant && (slot == SLOT_W'(g));
  end

endmodule

// File: rtl/dbgcfg_field.sv
module dbgcfg_field #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  logic [W-1:0] value_q;
  logic [W-1:0] value_d;

  always_comb begin
    value_d = value_q;
    if (we) value_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) value_q <= '0;
    else        value_q <= value_d;
  end

  assign q = value_q;

  AST_FIELD_HOLDS_WITHOUT_WE: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(value_q)); // R2

endmodule

// File: rtl/dbgcfg_bank.sv
module dbgcfg_bank
  import dbgcfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [31:0] req_index,
  input  logic [31:0] req_wdata,
  input  logic [31:0] req_key,
  output logic        rsp_done,
  output logic [31:0] rsp_rdata,
  output logic        rsp_fault,
  output logic [6:0]  cfg_ctrl,
  output logic        cfg_mode_enter,
  output logic [31:0] cfg_dmatch,
  output logic [31:0] cfg_dmask,
  output logic [11:0] cfg_amask
);

  logic                rst_sync_n;
  logic                grant;
  logic                fault;
  logic [SLOT_W-1:0]   slot;
  logic [NUM_REGS-1:0] hit;
  logic [DATA_W-1:0]   slot_val [NUM_REGS];

  logic              done_q,  done_d;
  logic              fault_q, fault_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  dbgcfg_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dbgcfg_decode u_decode (
    .req_valid (req_valid),
    .req_index (req_index),
    .req_key   (req_key),
    .grant     (grant),
    .fault     (fault),
    .slot      (slot),
    .hit       (hit)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
    localparam int unsigned FW = slot_width(g);
    logic [FW-1:0] field_q;

    dbgcfg_field #(.W(FW)) u_field (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .we    (hit[g] && req_write),
      .wdata (req_wdata[FW-1:0]),
      .q     (field_q)
    );

    assign slot_val[g] = DATA_W'(field_q);
  end

  // Response next state.
  always_comb begin
    done_d  = req_valid;
    fault_d = fault;
    rdata_d = '0;
    if (grant && !req_write) rdata_d = slot_val[slot];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q  <= done_d;
      fault_q <= fault_d;
      rdata_q <= rdata_d;
    end
  end

  assign rsp_done       = done_q;
  assign rsp_fault      = fault_q;
  assign rsp_rdata      = rdata_q;
  assign cfg_ctrl       = slot_val[SLOT_CTRL][6:0];
  assign cfg_mode_enter = slot_val[SLOT_CTRL][7];
  assign cfg_dmatch     = slot_val[SLOT_DMATCH];
  assign cfg_dmask      = slot_val[SLOT_DMASK];
  assign cfg_amask      = slot_val[SLOT_AMASK][11:0];

  AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |=> rsp_done); // R8
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid |=> (!rsp_done && !rsp_fault && rsp_rdata == '0)); // R8
  AST_FAULT_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_fault |-> (rsp_rdata == '0)); // R4
  AST_FAULT_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && !grant) |=> ($stable(cfg_ctrl) && $stable(cfg_mode_enter) &&
      $stable(cfg_dmatch) && $stable(cfg_dmask) && $stable(cfg_amask))); // R4
  AST_SINGLE_SLOT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(hit)); // R5
  AST_WRITE_RESP_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_write) |=> (rsp_rdata == '0)); // R3

endmodule

// File: tb/dbgcfg_bank_bench.sv
module dbgcfg_bank_bench;

  localparam logic [31:0] KEY     = 32'h9C5A_203A;
  localparam logic [31:0] I_CTRL  = 32'hC001_1024;
  localparam logic [31:0] I_MATCH = 32'hC001_1025;
  localparam logic [31:0] I_MASK  = 32'hC001_1026;
  localparam logic [31:0] I_AMASK = 32'hC001_1027;

  typedef struct packed {
    logic        wr;
    logic [31:0] idx;
    logic [31:0] wd;
    logic [31:0] key;
    logic        exp_flt;
    logic [31:0] exp_rd;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b1, I_CTRL,  32'hFFFF_FF85, KEY,           1'b0, 32'h0},          // R2 R6
    '{1'b0, I_CTRL,  32'h0,         KEY,           1'b0, 32'h0000_0085},  // R3 R6
    '{1'b1, I_MATCH, 32'hDEAD_BEEF, KEY,           1'b0, 32'h0},          // R2
    '{1'b0, I_MATCH, 32'h0,         KEY,           1'b0, 32'hDEAD_BEEF},  // R3
    '{1'b1, I_MASK,  32'h0F0F_00FF, KEY,           1'b0, 32'h0},          // R2
    '{1'b0, I_MASK,  32'h0,         KEY,           1'b0, 32'h0F0F_00FF},  // R3
    '{1'b1, I_AMASK, 32'hFFFF_FABC, KEY,           1'b0, 32'h0},          // R6
    '{1'b0, I_AMASK, 32'h0,         KEY,           1'b0, 32'h0000_0ABC},  // R6
    '{1'b1, I_CTRL,  32'h0000_0011, 32'h9C5A_203B, 1'b1, 32'h0},          // R4
    '{1'b0, I_CTRL,  32'h0,         32'h0,         1'b1, 32'h0},          // R4
    '{1'b1, 32'hC001_1028, 32'h1234_5678, KEY,     1'b1, 32'h0},          // R5
    '{1'b0, 32'hC001_1023, 32'h0,   KEY,           1'b1, 32'h0},          // R5
    '{1'b0, I_CTRL,  32'h0,         KEY,           1'b0, 32'h0000_0085},  // R4 state kept
    '{1'b1, 32'h0001_1024, 32'h0000_0055, KEY,     1'b1, 32'h0},          // R5
    '{1'b0, I_AMASK, 32'h0,         KEY,           1'b0, 32'h0000_0ABC}   // R5 state kept
  };

  logic        clk;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [31:0] req_index, req_wdata, req_key;
  logic        rsp_done, rsp_fault, cfg_mode_enter;
  logic [31:0] rsp_rdata, cfg_dmatch, cfg_dmask;
  logic [6:0]  cfg_ctrl;
  logic [11:0] cfg_amask;

  int checks;
  int failures;
  bit finished;

  // Bench model of the stored registers.
  logic [7:0]  m_ctrl;
  logic [31:0] m_match, m_mask;
  logic [11:0] m_amask;

  dbgcfg_bank u_dbgcfg_bank (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_index(req_index),
    .req_wdata(req_wdata), .req_key(req_key),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_fault(rsp_fault),
    .cfg_ctrl(cfg_ctrl), .cfg_mode_enter(cfg_mode_enter),
    .cfg_dmatch(cfg_dmatch), .cfg_dmask(cfg_dmask), .cfg_amask(cfg_amask)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_cfg(input string req);
    chk(req, {24'h0, cfg_mode_enter, cfg_ctrl}, {24'h0, m_ctrl});
    chk(req, cfg_dmatch, m_match);
    chk(req, cfg_dmask, m_mask);
    chk(req, {20'h0, cfg_amask}, {20'h0, m_amask});
  endtask

  task automatic drive(input logic wr, input logic [31:0] idx,
                       input logic [31:0] wd, input logic [31:0] key);
    req_valid = 1'b1; req_write = wr; req_index = idx; req_wdata = wd; req_key = key;
  endtask

  task automatic idle();
    req_valid = 1'b0; req_write = 1'b0; req_index = '0; req_wdata = '0; req_key = '0;
  endtask

  task automatic model_write(input logic [31:0] idx, input logic [31:0] wd);
    case (idx)
      I_CTRL:  m_ctrl  = wd[7:0];
      I_MATCH: m_match = wd;
      I_MASK:  m_mask  = wd;
      I_AMASK: m_amask = wd[11:0];
      default: ;
    endcase
  endtask

  task automatic model_clear();
    m_ctrl = '0; m_match = '0; m_mask = '0; m_amask = '0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    checks = 0; failures = 0; finished = 1'b0;
    model_clear();
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state while reset is held
    chk("R1 done in reset", {31'h0, rsp_done}, 32'h0);
    chk_cfg("R1 cfg in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 done after reset", {31'h0, rsp_done}, 32'h0);
    chk_cfg("R1 cfg after reset");
    // R8: idle gives quiet response
    chk("R8 idle rdata/fault", {rsp_rdata[30:0], rsp_fault}, 32'h0);

    // R1 reads after reset return zero
    drive(1'b0, I_MATCH, '0, KEY);
    @(negedge clk); idle();
    chk("R1 read zero after reset", rsp_rdata, 32'h0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].wr, VECS[i].idx, VECS[i].wd, VECS[i].key);
      @(negedge clk);
      idle();
      if (VECS[i].wr && !VECS[i].exp_flt) model_write(VECS[i].idx, VECS[i].wd);
      chk($sformatf("R8 vec%0d done", i), {31'h0, rsp_done}, 32'h1);
      chk($sformatf("R4/R5 vec%0d fault", i), {31'h0, rsp_fault}, {31'h0, VECS[i].exp_flt});
      chk($sformatf("R3 vec%0d rdata", i), rsp_rdata, VECS[i].exp_rd);
      chk_cfg($sformatf("R2 vec%0d cfg", i));
      @(negedge clk);
      chk($sformatf("R8 vec%0d single pulse", i), {31'h0, rsp_done}, 32'h0);
    end

    // R7: mode-entry bit separate from control bits
    drive(1'b1, I_CTRL, 32'h0000_0080, KEY);
    @(negedge clk); idle();
    chk("R7 mode bit set", {31'h0, cfg_mode_enter}, 32'h1);
    chk("R7 ctrl bits clear", {25'h0, cfg_ctrl}, 32'h0);
    drive(1'b1, I_CTRL, 32'h0000_007F, KEY);
    @(negedge clk); idle();
    chk("R7 mode bit clear", {31'h0, cfg_mode_enter}, 32'h0);
    chk("R7 ctrl bits set", {25'h0, cfg_ctrl}, 32'h7F);
    m_ctrl = 8'h7F;

    // R2: back-to-back write then read of the same register
    drive(1'b1, I_AMASK, 32'h0000_0123, KEY);
    @(negedge clk);
    chk("R2 b2b write done", {31'h0, rsp_done}, 32'h1);
    chk("R2 b2b cfg updated with done", {20'h0, cfg_amask}, 32'h123);
    drive(1'b0, I_AMASK, '0, KEY);
    @(negedge clk); idle();
    chk("R3 b2b read new value", rsp_rdata, 32'h123);
    chk("R8 b2b second done", {31'h0, rsp_done}, 32'h1);
    m_amask = 12'h123;

    // R4: single-bit key error, then good read shows no change
    drive(1'b1, I_MATCH, 32'h0, KEY ^ 32'h8000_0000);
    @(negedge clk); idle();
    chk("R4 high key bit fault", {31'h0, rsp_fault}, 32'h1);
    chk_cfg("R4 cfg unchanged");

    // R1: reset while configured clears everything
    rst_n = 1'b0;
    @(negedge clk);
    model_clear();
    chk_cfg("R1 async clear");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_cfg("R1 cleared after re-release");

    finish_run();
  end

endmodule